// File: doc/BRIEF.md
# Line-Splitting DMA Request Sequencer

This block accepts one DMA request at a time from an upstream requester: a start byte address, a byte length, a direction and, for stores, up to a full request of write data. It turns the request into a chain of memory transactions no wider than one cache line and sends them one after another over a valid/ready channel to a downstream memory queue. A transaction goes out only after the one before it has finished, that is after the memory side acknowledged a store or returned line data for a load. When the last transaction finishes, the block returns a response, carrying the assembled read data, to the requester.

Only the first transaction may begin in the middle of a line; it is cut short at the line boundary. Every later transaction begins on a line boundary. A request that arrives while the block is busy is refused rather than queued. The block remembers that it refused someone and sends a one-cycle retry pulse when the active request ends. A test-mode input turns that memory off. A drain input asks the block to report whether work is outstanding; it answers with a stall indication while busy and a drain-done pulse once idle.

Top module: `line_dma_seq`

## Requirements
- R1: A request is accepted (reqAccept high) only while the block is idle; while busy, reqValid gives reqFull high and reqAccept low, and the refused request is not stored or issued.
- R2: A refusal while testerMode is low sets a retry flag; in the cycle after the final transaction's memDone edge, retryPulse is high for one cycle and the flag is cleared.
- R3: With testerMode high, a refusal leaves no retry flag, and no retryPulse follows completion.
- R4: The first transaction's address is the start address and its length is the request length if (start mod 64) plus length is at most 64, else 64 minus (start mod 64).
- R5: Each later transaction's address is the start address plus the bytes issued so far, with its six low bits zero, and its length is the smaller of the remaining bytes and 64.
- R6: At most one transaction is in flight: memValid stays low from the memReady handshake until memDone arrives.
- R7: For a load, rspData byte i equals byte (address mod 64) of the returned line holding address start+i, for every i below the length; the first transaction's bytes are taken from the start offset, later ones from line byte 0.
- R8: For a store, memByteEn bit k is high exactly for line bytes k from the transaction's line offset up to offset plus length minus one, and memData byte k carries request byte (bytes issued before this transaction) plus k minus the offset; the first transaction's offset is start mod 64, later ones use 0.
- R9: In the cycle after the final memDone edge, busy is low, rspValid is high for one cycle only if reqNeedResp was high, and a new request is accepted in that same cycle.
- R10: While drainReq is high and work is outstanding, drainStall is high and drainDone low; drainDone pulses in the cycle after the outstanding request completes, or in the cycle after drainReq is seen while idle.
- R11: After reset the block is idle: busy, memValid, rspValid, retryPulse and drainDone are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| testerMode | input | 1 | Suppresses recording of refused requests |
| reqValid | input | 1 | Upstream request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqNeedResp | input | 1 | Request expects a response |
| reqAddr | input | 32 | Start byte address |
| reqLen | input | 9 | Byte length, 1 to 256 |
| reqData | input | 2048 | Store data, byte i in bits 8i+7:8i |
| reqAccept | output | 1 | Request taken this cycle |
| reqFull | output | 1 | Request refused this cycle (busy) |
| memValid | output | 1 | Downstream transaction valid |
| memReady | input | 1 | Downstream accepts the transaction |
| memAddr | output | 32 | Transaction byte address |
| memLen | output | 7 | Transaction byte length |
| memStore | output | 1 | 1 = store, 0 = load |
| memData | output | 512 | Store data placed at line byte positions |
| memByteEn | output | 64 | Line byte enables |
| memDone | input | 1 | Transaction finished (ack or data) |
| memDoneData | input | 512 | Returned full line for loads |
| rspValid | output | 1 | Response pulse to requester |
| rspData | output | 2048 | Assembled load data |
| retryPulse | output | 1 | Refused requester may try again |
| drainReq | input | 1 | Drain query |
| drainStall | output | 1 | Drain requested while work outstanding |
| drainDone | output | 1 | Drain complete pulse |
| busy | output | 1 | A request is outstanding |

## Verification
The bench aims at requests that start mid-line and spill into further lines, a request that fits inside one line away from its start, a store with a one-byte head and tail, and the maximum length. A design that clipped the first chunk wrongly or offset later chunks would issue misaligned addresses or wrong lengths, and one that took read bytes from the start offset on every line would scramble the response. Refusal while busy is exercised in both tester modes, with a new request presented in the very cycle the retry pulse appears, so a design that clears busy late or queues the refused request would be caught. Drain is queried both idle and busy, exposing a drain-done that fires early or never.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seqState_t;

  typedef struct packed {
    logic load;     // capture a new request and set up the first chunk
    logic advance;  // chunk finished, more remain: set up the next chunk
    logic capture;  // returned load data is written into the response buffer
  } seqStrobes_t;
endpackage

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        testerMode,
  input  logic        reqValid,
  input  logic        memReady,
  input  logic        memDone,
  input  logic        drainReq,
  input  logic        lastChunk,
  input  logic        curWrite,
  input  logic        curNeedResp,
  output logic        reqAccept,
  output logic        reqFull,
  output logic        memValid,
  output logic        busy,
  output logic        rspValid,
  output logic        retryPulse,
  output logic        drainStall,
  output logic        drainDone,
  output seqStrobes_t strobes
);
  seqState_t state;
  logic retryFlag, drainPending;
  logic finishNow, chunkDone, noteRefusal;

  assign busy        = (state != ST_IDLE);
  assign reqAccept   = reqValid && !busy;
  assign reqFull     = reqValid && busy;
  assign memValid    = (state == ST_ISSUE);
  assign chunkDone   = (state == ST_WAIT) && memDone;
  assign finishNow   = chunkDone && lastChunk;
  assign noteRefusal = reqFull && !testerMode;
  assign drainStall  = drainReq && busy;

  always_comb begin
    strobes.load    = reqAccept;
    strobes.advance = chunkDone && !lastChunk;
    strobes.capture = chunkDone && !curWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      retryFlag    <= 1'b0;
      drainPending <= 1'b0;
      rspValid     <= 1'b0;
      retryPulse   <= 1'b0;
      drainDone    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (reqAccept) state <= ST_ISSUE;
        ST_ISSUE: if (memReady) state <= ST_WAIT;
        ST_WAIT:  if (memDone) state <= lastChunk ? ST_IDLE : ST_ISSUE;
        default:  state <= ST_IDLE;
      endcase
      if (finishNow) retryFlag <= 1'b0;
      else if (noteRefusal) retryFlag <= 1'b1;
      retryPulse   <= finishNow && (retryFlag || noteRefusal);
      rspValid     <= finishNow && curNeedResp;
      drainPending <= busy && !finishNow && (drainPending || drainReq);
      drainDone    <= (drainReq && !busy && !reqAccept) ||
                      (finishNow && (drainPending || drainReq));
    end
  end

  AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid)); // R1
  AST_RETRY_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    retryPulse |-> !busy && $past(memDone)); // R2
  AST_RSP_ONE_LATE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !busy && $past(memDone)); // R9
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R9
  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    drainDone |-> !busy); // R10
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> !memValid); // R6
endmodule

// File: rtl/dmaseq_dpath.sv
module dmaseq_dpath
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int BUF_BITS  = MAX_LEN * 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobes_t           strobes,
  input  logic                  memValid,
  input  logic                  reqWrite,
  input  logic                  reqNeedResp,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [LEN_W-1:0]      reqLen,
  input  logic [BUF_BITS-1:0]   reqData,
  input  logic [LINE_BITS-1:0]  memDoneData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [CLEN_W-1:0]     memLen,
  output logic                  memStore,
  output logic [LINE_BITS-1:0]  memData,
  output logic [LINE_BYTES-1:0] memByteEn,
  output logic [BUF_BITS-1:0]   rspData,
  output logic                  lastChunk,
  output logic                  curNeedResp
);
  logic [ADDR_W-1:0]   startAddr, chunkAddr, nextAddr;
  logic [LEN_W-1:0]    totalLen, bytesIssued, bytesDone, remLen;
  logic [CLEN_W-1:0]   chunkLen, firstLen, nextLen;
  logic [OFF_W-1:0]    chunkOff, reqOff;
  logic [LEN_W:0]      reqSpan;
  logic                isWrite;
  logic [BUF_BITS-1:0] wrBuf, rdBuf, insData, insMask;
  logic [LINE_BYTES:0] lenOnes;
  logic [LINE_BYTES-1:0] lenBytes;
  logic [LINE_BITS-1:0]  lenBits, lineShifted, wrSlice;

  // first chunk is clipped at the line boundary
  assign reqOff  = reqAddr[OFF_W-1:0];
  assign reqSpan = (LEN_W+1)'(reqLen) + (LEN_W+1)'(reqOff);
  always_comb begin
    if (reqSpan <= (LEN_W+1)'(LINE_BYTES)) firstLen = CLEN_W'(reqLen);
    else firstLen = CLEN_W'(LINE_BYTES) - CLEN_W'(reqOff);
  end

  // later chunks start at start + issued and take up to one line
  assign remLen   = totalLen - bytesIssued;
  assign nextAddr = startAddr + ADDR_W'(bytesIssued);
  always_comb begin
    if (remLen < LEN_W'(LINE_BYTES)) nextLen = CLEN_W'(remLen);
    else nextLen = CLEN_W'(LINE_BYTES);
  end

  // byte and bit masks of the current chunk, aligned to line byte 0
  assign lenOnes  = ((LINE_BYTES+1)'(1) << chunkLen) - (LINE_BYTES+1)'(1);
  assign lenBytes = lenOnes[LINE_BYTES-1:0];
  for (genvar g = 0; g < LINE_BYTES; g++) begin : gByteMask
    assign lenBits[g*8 +: 8] = {8{lenBytes[g]}};
  end

  // load path: line bytes from chunkOff go to buffer position bytesDone
  assign lineShifted = (memDoneData >> {chunkOff, 3'b000}) & lenBits;
  assign insData     = BUF_BITS'(lineShifted) << {bytesDone, 3'b000};
  assign insMask     = BUF_BITS'(lenBits) << {bytesDone, 3'b000};

  // store path: request bytes from bytesDone go to line byte chunkOff
  assign wrSlice   = LINE_BITS'(wrBuf >> {bytesDone, 3'b000}) & lenBits;
  assign memData   = wrSlice << {chunkOff, 3'b000};
  assign memByteEn = lenBytes << chunkOff;

  assign memAddr     = chunkAddr;
  assign memLen      = chunkLen;
  assign memStore    = isWrite;
  assign rspData     = rdBuf;
  assign lastChunk   = (bytesIssued == totalLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr   <= '0;
      chunkAddr   <= '0;
      totalLen    <= '0;
      bytesIssued <= '0;
      bytesDone   <= '0;
      chunkLen    <= '0;
      chunkOff    <= '0;
      isWrite     <= 1'b0;
      curNeedResp <= 1'b0;
      wrBuf       <= '0;
      rdBuf       <= '0;
    end else begin
      if (strobes.load) begin
        startAddr   <= reqAddr;
        chunkAddr   <= reqAddr;
        totalLen    <= reqLen;
        chunkLen    <= firstLen;
        chunkOff    <= reqOff;
        bytesDone   <= '0;
        bytesIssued <= LEN_W'(firstLen);
        isWrite     <= reqWrite;
        curNeedResp <= reqNeedResp;
        wrBuf       <= reqData;
        rdBuf       <= '0;
      end
      if (strobes.capture) rdBuf <= (rdBuf & ~insMask) | insData;
      if (strobes.advance) begin
        chunkAddr   <= nextAddr;
        chunkLen    <= nextLen;
        chunkOff    <= '0;
        bytesDone   <= bytesIssued;
        bytesIssued <= bytesIssued + LEN_W'(nextLen);
      end
    end
  end

  AST_CHUNK_IN_LINE: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (CLEN_W+1)'(chunkAddr[OFF_W-1:0]) + (CLEN_W+1)'(chunkLen)
                 <= (CLEN_W+1)'(LINE_BYTES)); // R4
  AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && bytesDone != '0) |-> chunkAddr[OFF_W-1:0] == '0); // R5
  AST_CHUNK_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> chunkLen != '0 && $countones(memByteEn) == int'(chunkLen)); // R8
endmodule

// File: rtl/line_dma_seq.sv
module line_dma_seq
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  localparam int CLEN_W    = $clog2(LINE_BYTES + 1),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int BUF_BITS  = MAX_LEN * 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  testerMode,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic                  reqNeedResp,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [LEN_W-1:0]      reqLen,
  input  logic [BUF_BITS-1:0]   reqData,
  output logic                  reqAccept,
  output logic                  reqFull,
  output logic                  memValid,
  input  logic                  memReady,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [CLEN_W-1:0]     memLen,
  output logic                  memStore,
  output logic [LINE_BITS-1:0]  memData,
  output logic [LINE_BYTES-1:0] memByteEn,
  input  logic                  memDone,
  input  logic [LINE_BITS-1:0]  memDoneData,
  output logic                  rspValid,
  output logic [BUF_BITS-1:0]   rspData,
  output logic                  retryPulse,
  input  logic                  drainReq,
  output logic                  drainStall,
  output logic                  drainDone,
  output logic                  busy
);
  seqStrobes_t strobes;
  logic lastChunk, curNeedResp;

  dmaseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .testerMode(testerMode), .reqValid(reqValid),
    .memReady(memReady), .memDone(memDone), .drainReq(drainReq),
    .lastChunk(lastChunk), .curWrite(memStore), .curNeedResp(curNeedResp),
    .reqAccept(reqAccept), .reqFull(reqFull), .memValid(memValid),
    .busy(busy), .rspValid(rspValid), .retryPulse(retryPulse),
    .drainStall(drainStall), .drainDone(drainDone), .strobes(strobes)
  );

  dmaseq_dpath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memValid(memValid),
    .reqWrite(reqWrite), .reqNeedResp(reqNeedResp), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqData(reqData), .memDoneData(memDoneData),
    .memAddr(memAddr), .memLen(memLen), .memStore(memStore),
    .memData(memData), .memByteEn(memByteEn), .rspData(rspData),
    .lastChunk(lastChunk), .curNeedResp(curNeedResp)
  );
endmodule

// File: tb/line_dma_seq_bench.sv
module line_dma_seq_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic testerMode = 0, reqValid = 0, reqWrite = 0, reqNeedResp = 0;
  logic [31:0] reqAddr = '0;
  logic [8:0] reqLen = '0;
  logic [2047:0] reqData = '0;
  logic reqAccept, reqFull, memValid, memStore, rspValid, retryPulse;
  logic drainStall, drainDone, busy;
  logic memReady = 0, memDone = 0, drainReq = 0;
  logic [31:0] memAddr;
  logic [6:0] memLen;
  logic [511:0] memData, memDoneData = '0;
  logic [63:0] memByteEn;
  logic [2047:0] rspData;

  always #10 clk = ~clk;

  line_dma_seq u_line_dma_seq (
    .clk(clk), .rstN(rstN), .testerMode(testerMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqNeedResp(reqNeedResp), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqData(reqData), .reqAccept(reqAccept),
    .reqFull(reqFull), .memValid(memValid), .memReady(memReady),
    .memAddr(memAddr), .memLen(memLen), .memStore(memStore),
    .memData(memData), .memByteEn(memByteEn), .memDone(memDone),
    .memDoneData(memDoneData), .rspValid(rspValid), .rspData(rspData),
    .retryPulse(retryPulse), .drainReq(drainReq), .drainStall(drainStall),
    .drainDone(drainDone), .busy(busy)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [7:0] mem [1024];
  logic [7:0] snap [1024];
  int curAddr, curLen, curWrite, curResp, curSeed, nChunks;
  int expCAddr [8];
  int expCLen [8];
  int expCDone [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] patByte(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + 1) & 255);
  endfunction

  task automatic startReq(input int addr, input int len, input int wr,
                          input int resp, input int seed);
    int a, rem, done, l;
    curAddr = addr; curLen = len; curWrite = wr; curResp = resp; curSeed = seed;
    a = addr; rem = len; done = 0; nChunks = 0;
    while (rem > 0) begin
      l = 64 - (a % 64);
      if (l > rem) l = rem;
      expCAddr[nChunks] = a; expCLen[nChunks] = l; expCDone[nChunks] = done;
      nChunks++; a += l; rem -= l; done += l;
    end
    for (int i = 0; i < 1024; i++) snap[i] = mem[i];
    for (int i = 0; i < 256; i++) reqData[i*8 +: 8] = patByte(seed, i);
    reqAddr = 32'(addr); reqLen = 9'(len); reqWrite = wr[0];
    reqNeedResp = resp[0]; reqValid = 1'b1;
    #1;
    chk(reqAccept == 1'b1 && reqFull == 1'b0, "R1", "accept when idle",
        longint'(reqAccept), 1);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic serviceChunk(input int idx);
    int t, off, base;
    logic [63:0] expEn;
    bit dataOk;
    t = 0;
    while (!memValid && t < 50) begin @(negedge clk); t++; end
    chk(memValid == 1'b1, "R6", "chunk issued", longint'(memValid), 1);
    chk(int'(memAddr) == expCAddr[idx], idx == 0 ? "R4" : "R5", "chunk address",
        longint'(memAddr), longint'(expCAddr[idx]));
    chk(int'(memLen) == expCLen[idx], idx == 0 ? "R4" : "R5", "chunk length",
        longint'(memLen), longint'(expCLen[idx]));
    off = expCAddr[idx] % 64;
    base = expCAddr[idx] - off;
    if (curWrite != 0) begin
      expEn = '0;
      for (int k = 0; k < 64; k++) if (k >= off && k < off + expCLen[idx]) expEn[k] = 1'b1;
      dataOk = 1;
      for (int k = off; k < off + expCLen[idx]; k++)
        if (memData[k*8 +: 8] != patByte(curSeed, expCDone[idx] + k - off)) dataOk = 0;
      chk(memByteEn == expEn, "R8", "byte enables", longint'(memByteEn), longint'(expEn));
      chk(dataOk, "R8", "store data placement", longint'(dataOk), 1);
      for (int k = 0; k < 64; k++) if (memByteEn[k]) mem[(base + k) % 1024] = memData[k*8 +: 8];
    end
    memReady = 1'b1;
    @(negedge clk);
    memReady = 1'b0;
    @(negedge clk);
    chk(memValid == 1'b0, "R6", "no issue before done", longint'(memValid), 0);
    for (int k = 0; k < 64; k++) memDoneData[k*8 +: 8] = mem[(base + k) % 1024];
    memDone = 1'b1;
    @(negedge clk);
    memDone = 1'b0;
  endtask

  task automatic finishReq();
    int bad;
    logic [7:0] e;
    for (int i = 0; i < nChunks; i++) serviceChunk(i);
    chk(busy == 1'b0, "R9", "idle after final chunk", longint'(busy), 0);
    chk(rspValid == curResp[0], "R9", "response pulse", longint'(rspValid),
        longint'(curResp));
    bad = 0;
    if (curWrite == 0) begin
      for (int i = 0; i < curLen; i++)
        if (rspData[i*8 +: 8] != snap[(curAddr + i) % 1024]) bad++;
      chk(bad == 0, "R7", "assembled load bytes wrong", longint'(bad), 0);
    end else begin
      for (int i = 0; i < 1024; i++) begin
        e = (i >= curAddr && i < curAddr + curLen) ? patByte(curSeed, i - curAddr) : snap[i];
        if (mem[i] != e) bad++;
      end
      chk(bad == 0, "R8", "memory bytes wrong after store", longint'(bad), 0);
    end
  endtask

  task automatic tReset();
    chk(busy == 0 && memValid == 0, "R11", "idle after reset", longint'(busy), 0);
    chk(rspValid == 0 && retryPulse == 0 && drainDone == 0, "R11",
        "pulses low after reset", longint'(rspValid), 0);
  endtask

  task automatic tPlain(input int addr, input int len, input int wr, input int resp,
                        input int seed);
    startReq(addr, len, wr, resp, seed);
    finishReq();
    @(negedge clk);
    chk(rspValid == 1'b0, "R9", "response lasts one cycle", longint'(rspValid), 0);
  endtask

  task automatic tRefuse(input bit tmode);
    testerMode = tmode;
    startReq(32'h200, 100, 0, 1, 9);
    reqAddr = 32'h3A0; reqLen = 9'd8; reqValid = 1'b1;
    #1;
    chk(reqAccept == 0 && reqFull == 1, "R1", "refused while busy",
        longint'(reqAccept), 0);
    @(negedge clk);
    reqValid = 1'b0;
    chk(int'(memAddr) == 32'h200, "R1", "refused request not taken",
        longint'(memAddr), 32'h200);
    finishReq();
    chk(retryPulse == !tmode, tmode ? "R3" : "R2", "retry after completion",
        longint'(retryPulse), longint'(!tmode));
    startReq(32'h0C4, 3, 0, 1, 11);  // R9: accepted in the completion cycle
    finishReq();
    chk(retryPulse == 1'b0, tmode ? "R3" : "R2", "no second retry",
        longint'(retryPulse), 0);
    testerMode = 1'b0;
  endtask

  task automatic tDrain();
    drainReq = 1'b1;
    @(negedge clk);
    chk(drainDone == 1'b1, "R10", "drain done while idle", longint'(drainDone), 1);
    drainReq = 1'b0;
    @(negedge clk);
    startReq(32'h0F0, 20, 0, 1, 5);
    drainReq = 1'b1;
    #1;
    chk(drainStall == 1'b1, "R10", "drain stall while busy", longint'(drainStall), 1);
    @(negedge clk);
    chk(drainDone == 1'b0, "R10", "no drain done while busy", longint'(drainDone), 0);
    drainReq = 1'b0;
    finishReq();
    chk(drainDone == 1'b1, "R10", "drain done after completion", longint'(drainDone), 1);
    @(negedge clk);
    chk(drainDone == 1'b0, "R10", "drain done is a pulse", longint'(drainDone), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 5 + 3) & 255);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPlain(32'h100, 64, 0, 1, 1);   // aligned single line load
    tPlain(32'h013, 200, 0, 1, 2);  // mid-line start, four chunks
    tPlain(32'h22A, 100, 1, 1, 3);  // mid-line store
    tPlain(32'h045, 5, 0, 1, 4);    // short load inside one line
    tPlain(32'h300, 256, 0, 1, 6);  // maximum length
    tPlain(32'h17F, 130, 1, 1, 7);  // one-byte head and tail store
    tPlain(32'h080, 10, 1, 0, 8);   // no response expected
    tRefuse(1'b0);
    tRefuse(1'b1);
    tDrain();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule